// File: doc/BRIEF.md
# Multi-Ring Ethernet DMA Control Register File

This block is the 32-bit register file that sits in front of a multi-ring Ethernet DMA engine. A simple request port (valid, write, address, write data) reaches a 4 KB window of word registers. Each register has one of four access behaviours: read-write, write-only, write-1-to-clear or read-only. Read data comes back one cycle after the request. The DMA engines themselves are not part of the block. They see the register file through its outputs: a control word, a command word, per-ring restart strobes and three interrupt lines.

Hardware reports events and ring halts through single-cycle set inputs. Software acknowledges them by writing ones. For the halt flags, that acknowledge also produces the restart strobe for the matching ring. The transmit and receive sides follow different rules for when a strobe fires. Each ring has a base register and a working pointer register. Loading a base also reloads the pointer, with the address aligned down to 8 bytes.

Top module: `erf_regfile`

## Requirements
- R1: The register index is address bits [11:2]. Address bits [1:0] are ignored, and every access is a full 32-bit word.
- R2: A read request returns data on `rsp_rdata` with `rsp_valid` high exactly one cycle later. Write-only registers (command, 0x014) and undefined locations read as zero. All other registers return their stored value.
- R3: Control (0x008) and mask (0x004) are read-write and take the written value. Command (0x014) is write-only and its value appears on `cmd_word`, with control on `dma_ctl`. Writes to the read-only identity register (0x018) and to undefined locations change nothing.
- R4: In transmit status (0x00C), ring i halts in bit 31−i, which `tx_halt_set[i]` sets. A write with bit 31−i at 1 clears that flag and pulses `tx_restart[i]` for one cycle, one cycle after the write.
- R5: In receive status (0x010), ring i halts in bit 23−i, which `rx_halt_set[i]` sets. A written 1 clears the flag. `rx_restart[i]` pulses only when the written bit is 1 and the stored bit was 0.
- R6: Writing transmit base n (0x100+4n) or receive base n (0x180+4n) stores the value with bits [2:0] cleared, and loads the same value into pointer n (0x140+4n for transmit, 0x1C0+4n for receive). A direct write to a pointer register stores the full value.
- R7: The event register (0x000) is write-1-to-clear. `evt_set` bits set it. A hardware set wins over a software clear of the same bit in the same cycle.
- R8: `irq_tx` is the registered AND of event bit 0 (transmit frame) and mask bit 0. `irq_rx` is the same for bit 1 (receive frame).
- R9: `irq_err` is high when any error-class event bit [15:8] is set together with its mask bit. Event bits [7:2] and [31:16] never raise it.
- R10: After reset, every register reads zero except the identity register, which reads `ID_VALUE`. All strobes and interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| evt_set | input | 32 | Hardware event set pulses |
| tx_halt_set | input | NUM_RINGS | Transmit ring halt set pulses |
| rx_halt_set | input | NUM_RINGS | Receive ring halt set pulses |
| tx_restart | output | NUM_RINGS | Transmit ring restart strobes |
| rx_restart | output | NUM_RINGS | Receive ring restart strobes |
| irq_tx | output | 1 | Transmit-frame interrupt |
| irq_rx | output | 1 | Receive-frame interrupt |
| irq_err | output | 1 | Error-class interrupt |
| dma_ctl | output | 32 | Control register value |
| cmd_word | output | 32 | Write-only command register value |

## Verification
The bench builds the block with its defaults: a 12-bit address, eight rings per direction and a fixed identity value. With eight rings, both the highest ring (bit 24 for transmit, bit 16 for receive) and the first undefined slot above each ring bank can be reached. The directed phase covers the receive rule in both cases: flags that were already set and flags that were clear. It also covers a same-cycle event set against a clear, and misaligned base values. A pseudo-random phase then mixes accesses to every register kind with sparse hardware set pulses.

// File: rtl/erf_pkg.sv
package erf_pkg;

    // single-register word indices
    localparam int unsigned IX_EVT  = 0;
    localparam int unsigned IX_MASK = 1;
    localparam int unsigned IX_CTL  = 2;
    localparam int unsigned IX_TSTS = 3;
    localparam int unsigned IX_RSTS = 4;
    localparam int unsigned IX_CMD  = 5;
    localparam int unsigned IX_ID   = 6;

    // ring banks: 16-word regions, region number = index / 16
    localparam int unsigned RING_SPAN  = 16;
    localparam int unsigned RGN_TBASE  = 4;
    localparam int unsigned RGN_TPTR   = 5;
    localparam int unsigned RGN_RBASE  = 6;
    localparam int unsigned RGN_RPTR   = 7;

    // status halt-flag top bits
    localparam int unsigned TX_TOP_BIT = 31;
    localparam int unsigned RX_TOP_BIT = 23;

    // event classes
    localparam logic [31:0] EVT_TXF   = 32'h0000_0001;
    localparam logic [31:0] EVT_RXF   = 32'h0000_0002;
    localparam logic [31:0] EVT_ERR   = 32'h0000_FF00;

    localparam logic [31:0] BASE_ALIGN = 32'h0000_0007;

    typedef struct packed {
        logic evt;
        logic mask;
        logic ctl;
        logic tsts;
        logic rsts;
        logic cmd;
        logic id;
        logic tbase;
        logic tptr;
        logic rbase;
        logic rptr;
    } sel_t;

endpackage

// File: rtl/erf_event_irq.sv
module erf_event_irq
    import erf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_evt,
    input  logic        wr_mask,
    input  logic [31:0] wdata,
    input  logic [31:0] evt_set,
    output logic [31:0] evt_q,
    output logic [31:0] mask_q,
    output logic        irq_tx,
    output logic        irq_rx,
    output logic        irq_err
);

    typedef struct packed {
        logic [31:0] evt;
        logic [31:0] mask;
        logic        tx;
        logic        rx;
        logic        err;
    } evt_st_t;

    evt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_evt) begin
            s_d.evt = s_q.evt & ~wdata;
        end
        // hardware set has priority over a same-cycle clear
        s_d.evt = s_d.evt | evt_set;
        if (wr_mask) begin
            s_d.mask = wdata;
        end
        s_d.tx  = |(s_d.evt & s_d.mask & EVT_TXF);
        s_d.rx  = |(s_d.evt & s_d.mask & EVT_RXF);
        s_d.err = |(s_d.evt & s_d.mask & EVT_ERR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt_q   = s_q.evt;
    assign mask_q  = s_q.mask;
    assign irq_tx  = s_q.tx;
    assign irq_rx  = s_q.rx;
    assign irq_err = s_q.err;

endmodule

// File: rtl/erf_halt_status.sv
module erf_halt_status #(
    parameter int unsigned NUM_RINGS = 8,
    parameter int unsigned TOP_BIT   = 31,
    parameter bit          EDGE_ONLY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [31:0]          wdata,
    input  logic [NUM_RINGS-1:0] halt_set,
    output logic [31:0]          stat_q,
    output logic [NUM_RINGS-1:0] restart_q
);

    function automatic logic [31:0] flag_mask();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < NUM_RINGS; i++) begin
            m[TOP_BIT - i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [31:0] FLAGS = flag_mask();

    typedef struct packed {
        logic [31:0]          stat;
        logic [NUM_RINGS-1:0] restart;
    } hs_st_t;

    hs_st_t s_d, s_q;

    logic [NUM_RINGS-1:0] hit;
    logic [NUM_RINGS-1:0] stored;
    logic [NUM_RINGS-1:0] arm;
    logic [31:0]          set_vec;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_RINGS; i++) begin
            hit[i]               = wr && wdata[TOP_BIT - i];
            stored[i]            = s_q.stat[TOP_BIT - i];
            set_vec[TOP_BIT - i] = halt_set[i];
        end
    end

    generate
        if (EDGE_ONLY) begin : g_edge
            assign arm = ~stored;
        end else begin : g_level
            assign arm = '1;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        s_d.restart = hit & arm;
        if (wr) begin
            s_d.stat = s_q.stat & ~wdata & FLAGS;
        end
        s_d.stat = s_d.stat | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_q    = s_q.stat;
    assign restart_q = s_q.restart;

endmodule

// File: rtl/erf_ring_bank.sv
module erf_ring_bank
    import erf_pkg::*;
#(
    parameter int unsigned NUM_RINGS = 8,
    parameter int unsigned RIX_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_base,
    input  logic                        wr_ptr,
    input  logic [RIX_W-1:0]            ring,
    input  logic [31:0]                 wdata,
    output logic [NUM_RINGS-1:0][31:0]  base_q,
    output logic [NUM_RINGS-1:0][31:0]  ptr_q
);

    typedef struct packed {
        logic [NUM_RINGS-1:0][31:0] base;
        logic [NUM_RINGS-1:0][31:0] ptr;
    } rb_st_t;

    rb_st_t      s_d, s_q;
    logic [31:0] aligned;

    always_comb begin
        s_d     = s_q;
        aligned = wdata & ~BASE_ALIGN;
        for (int i = 0; i < NUM_RINGS; i++) begin
            if (ring == RIX_W'(i)) begin
                if (wr_base) begin
                    s_d.base[i] = aligned;
                    s_d.ptr[i]  = aligned;
                end else if (wr_ptr) begin
                    s_d.ptr[i]  = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign base_q = s_q.base;
    assign ptr_q  = s_q.ptr;

endmodule

// File: rtl/erf_regfile.sv
module erf_regfile
    import erf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_RINGS = 8,
    parameter logic [31:0] ID_VALUE  = 32'h5A17_0001
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    input  logic [31:0]          evt_set,
    input  logic [NUM_RINGS-1:0] tx_halt_set,
    input  logic [NUM_RINGS-1:0] rx_halt_set,
    output logic [NUM_RINGS-1:0] tx_restart,
    output logic [NUM_RINGS-1:0] rx_restart,
    output logic                 irq_tx,
    output logic                 irq_rx,
    output logic                 irq_err,
    output logic [31:0]          dma_ctl,
    output logic [31:0]          cmd_word
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned RIX_W = $clog2(RING_SPAN);
    localparam int unsigned RGN_W = IDX_W - RIX_W;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] cmd;
        logic        rvalid;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [IDX_W-1:0] idx;
    logic [RIX_W-1:0] ring;
    logic [RGN_W-1:0] region;
    logic             ring_ok;
    logic             wr;
    logic             rd;
    sel_t             sel;
    logic             unused_addr_lanes;

    logic [31:0] evt_q, mask_q, tx_stat_q, rx_stat_q;
    logic [NUM_RINGS-1:0][31:0] tx_base_q, tx_ptr_q, rx_base_q, rx_ptr_q;

    assign idx               = req_addr[ADDR_W-1:2];
    assign ring              = idx[RIX_W-1:0];
    assign region            = idx[IDX_W-1:RIX_W];
    assign ring_ok           = ring < RIX_W'(NUM_RINGS);
    assign wr                = req_valid && req_write;
    assign rd                = req_valid && !req_write;
    assign unused_addr_lanes = ^req_addr[1:0];

    // address decode
    always_comb begin
        sel       = '0;
        sel.evt   = idx == IDX_W'(IX_EVT);
        sel.mask  = idx == IDX_W'(IX_MASK);
        sel.ctl   = idx == IDX_W'(IX_CTL);
        sel.tsts  = idx == IDX_W'(IX_TSTS);
        sel.rsts  = idx == IDX_W'(IX_RSTS);
        sel.cmd   = idx == IDX_W'(IX_CMD);
        sel.id    = idx == IDX_W'(IX_ID);
        sel.tbase = ring_ok && (region == RGN_W'(RGN_TBASE));
        sel.tptr  = ring_ok && (region == RGN_W'(RGN_TPTR));
        sel.rbase = ring_ok && (region == RGN_W'(RGN_RBASE));
        sel.rptr  = ring_ok && (region == RGN_W'(RGN_RPTR));
    end

    erf_event_irq u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_evt  (wr && sel.evt),
        .wr_mask (wr && sel.mask),
        .wdata   (req_wdata),
        .evt_set (evt_set),
        .evt_q   (evt_q),
        .mask_q  (mask_q),
        .irq_tx  (irq_tx),
        .irq_rx  (irq_rx),
        .irq_err (irq_err)
    );

    erf_halt_status #(
        .NUM_RINGS (NUM_RINGS),
        .TOP_BIT   (TX_TOP_BIT),
        .EDGE_ONLY (1'b0)
    ) u_txs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr && sel.tsts),
        .wdata     (req_wdata),
        .halt_set  (tx_halt_set),
        .stat_q    (tx_stat_q),
        .restart_q (tx_restart)
    );

    erf_halt_status #(
        .NUM_RINGS (NUM_RINGS),
        .TOP_BIT   (RX_TOP_BIT),
        .EDGE_ONLY (1'b1)
    ) u_rxs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr && sel.rsts),
        .wdata     (req_wdata),
        .halt_set  (rx_halt_set),
        .stat_q    (rx_stat_q),
        .restart_q (rx_restart)
    );

    erf_ring_bank #(
        .NUM_RINGS (NUM_RINGS),
        .RIX_W     (RIX_W)
    ) u_txring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_base (wr && sel.tbase),
        .wr_ptr  (wr && sel.tptr),
        .ring    (ring),
        .wdata   (req_wdata),
        .base_q  (tx_base_q),
        .ptr_q   (tx_ptr_q)
    );

    erf_ring_bank #(
        .NUM_RINGS (NUM_RINGS),
        .RIX_W     (RIX_W)
    ) u_rxring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_base (wr && sel.rbase),
        .wr_ptr  (wr && sel.rptr),
        .ring    (ring),
        .wdata   (req_wdata),
        .base_q  (rx_base_q),
        .ptr_q   (rx_ptr_q)
    );

    // generic registers, read path
    always_comb begin
        s_d        = s_q;
        s_d.rvalid = rd;
        s_d.rdata  = '0;
        if (wr && sel.ctl) begin
            s_d.ctl = req_wdata;
        end
        if (wr && sel.cmd) begin
            s_d.cmd = req_wdata;
        end
        if (rd) begin
            if (sel.evt)  s_d.rdata = evt_q;
            if (sel.mask) s_d.rdata = mask_q;
            if (sel.ctl)  s_d.rdata = s_q.ctl;
            if (sel.tsts) s_d.rdata = tx_stat_q;
            if (sel.rsts) s_d.rdata = rx_stat_q;
            if (sel.id)   s_d.rdata = ID_VALUE;
            for (int i = 0; i < NUM_RINGS; i++) begin
                if (ring == RIX_W'(i)) begin
                    if (sel.tbase) s_d.rdata = tx_base_q[i];
                    if (sel.tptr)  s_d.rdata = tx_ptr_q[i];
                    if (sel.rbase) s_d.rdata = rx_base_q[i];
                    if (sel.rptr)  s_d.rdata = rx_ptr_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rvalid;
    assign rsp_rdata = s_q.rdata;
    assign dma_ctl   = s_q.ctl;
    assign cmd_word  = s_q.cmd;

endmodule

// File: rtl/erf_regfile_chk.sv
module erf_regfile_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_RINGS = 8,
    parameter logic [31:0] ID_VALUE  = 32'h5A17_0001
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [31:0]                 req_wdata,
    input logic                        rsp_valid,
    input logic [31:0]                 rsp_rdata,
    input logic [31:0]                 evt_set,
    input logic [NUM_RINGS-1:0]        tx_restart,
    input logic [NUM_RINGS-1:0]        rx_restart,
    input logic                        irq_tx,
    input logic                        irq_err,
    input logic [31:0]                 evt_q,
    input logic [31:0]                 mask_q,
    input logic [31:0]                 rx_stat_q,
    input logic [NUM_RINGS-1:0][31:0]  tx_ptr_q
);

    logic [ADDR_W-3:0] cidx;
    logic              cwr;
    logic              crd;

    assign cidx = req_addr[ADDR_W-1:2];
    assign cwr  = req_valid && req_write;
    assign crd  = req_valid && !req_write;

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        crd |=> rsp_valid);

    p_wo_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (crd && cidx == 5) |=> (rsp_rdata == 32'h0));

    p_ro_holds_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (crd && cidx == 6) |=> (rsp_rdata == ID_VALUE));

    p_tx_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && cidx == 3 && req_wdata[31]) |=> tx_restart[0]);

    p_tx_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cwr && cidx == 3) |=> (tx_restart == '0));

    p_rx_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && cidx == 4 && req_wdata[23] && rx_stat_q[23]) |=> !rx_restart[0]);

    p_ptr_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && cidx == 64) |=> (tx_ptr_q[0] == ($past(req_wdata) & ~32'h7)));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 32'h0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

    p_irq_tx_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (evt_q[0] && mask_q[0]));

    p_irq_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> ((evt_q & mask_q & 32'h0000_FF00) != 32'h0));

endmodule

bind erf_regfile erf_regfile_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_RINGS (NUM_RINGS),
    .ID_VALUE  (ID_VALUE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .evt_set    (evt_set),
    .tx_restart (tx_restart),
    .rx_restart (rx_restart),
    .irq_tx     (irq_tx),
    .irq_err    (irq_err),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .rx_stat_q  (rx_stat_q),
    .tx_ptr_q   (tx_ptr_q)
);

// File: tb/erf_regfile_tb.sv
module erf_regfile_tb;

    localparam int          NR  = 8;
    localparam logic [31:0] IDV = 32'h5A17_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] evt_set = '0;
    logic [NR-1:0] tx_halt_set = '0;
    logic [NR-1:0] rx_halt_set = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NR-1:0] tx_restart, rx_restart;
    logic        irq_tx, irq_rx, irq_err;
    logic [31:0] dma_ctl, cmd_word;

    always #5 clk = ~clk;

    erf_regfile #(.ADDR_W(12), .NUM_RINGS(NR), .ID_VALUE(IDV)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .evt_set(evt_set), .tx_halt_set(tx_halt_set),
        .rx_halt_set(rx_halt_set), .tx_restart(tx_restart), .rx_restart(rx_restart),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
        .dma_ctl(dma_ctl), .cmd_word(cmd_word)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_evt, m_mask, m_ctl, m_cmd, m_txs, m_rxs;
    logic [31:0] m_tb[NR], m_tp[NR], m_rb[NR], m_rp[NR];
    logic        e_rv;
    logic [31:0] e_rd;
    string       e_tag;
    logic [NR-1:0] e_txr, e_rxr;
    logic        e_itx, e_irx, e_ierr;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_evt = '0; m_mask = '0; m_ctl = '0; m_cmd = '0; m_txs = '0; m_rxs = '0;
        for (int i = 0; i < NR; i++) begin
            m_tb[i] = '0; m_tp[i] = '0; m_rb[i] = '0; m_rp[i] = '0;
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int ix = int'(a[11:2]);
        int rg = ix / 16;
        int rn = ix % 16;
        case (ix)
            0: return m_evt;
            1: return m_mask;
            2: return m_ctl;
            3: return m_txs;
            4: return m_rxs;
            5: return 32'h0;
            6: return IDV;
            default: ;
        endcase
        if (rn < NR) begin
            case (rg)
                4: return m_tb[rn];
                5: return m_tp[rn];
                6: return m_rb[rn];
                7: return m_rp[rn];
                default: ;
            endcase
        end
        return 32'h0;
    endfunction

    function automatic string m_tag(input logic [11:0] a);
        int ix = int'(a[11:2]);
        if (a[1:0] != 2'b00) return "R1";
        case (ix)
            0: return "R7";
            1, 2, 6: return "R3";
            3: return "R4";
            4: return "R5";
            default: ;
        endcase
        if (ix >= 64 && ix < 128 && (ix % 16) < NR) return "R6";
        return "R2";
    endfunction

    task automatic step(input logic v, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input logic [31:0] es,
                        input logic [NR-1:0] th, input logic [NR-1:0] rh);
        int   ix = int'(a[11:2]);
        int   rg = ix / 16;
        int   rn = ix % 16;
        logic wr = v && w;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        evt_set = es; tx_halt_set = th; rx_halt_set = rh;
        e_rv  = v && !w;
        e_rd  = e_rv ? m_read(a) : 32'h0;
        e_tag = m_tag(a);
        for (int i = 0; i < NR; i++) begin
            e_txr[i] = wr && ix == 3 && d[31-i];
            e_rxr[i] = wr && ix == 4 && d[23-i] && !m_rxs[23-i];
        end
        if (wr) begin
            case (ix)
                0: m_evt = m_evt & ~d;
                1: m_mask = d;
                2: m_ctl = d;
                3: m_txs = m_txs & ~d;
                4: m_rxs = m_rxs & ~d;
                5: m_cmd = d;
                default: begin
                    if (rn < NR) begin
                        case (rg)
                            4: begin m_tb[rn] = d & ~32'h7; m_tp[rn] = d & ~32'h7; end
                            5: m_tp[rn] = d;
                            6: begin m_rb[rn] = d & ~32'h7; m_rp[rn] = d & ~32'h7; end
                            7: m_rp[rn] = d;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
        m_evt = m_evt | es;
        for (int i = 0; i < NR; i++) begin
            if (th[i]) m_txs[31-i] = 1'b1;
            if (rh[i]) m_rxs[23-i] = 1'b1;
        end
        e_itx  = m_evt[0] && m_mask[0];
        e_irx  = m_evt[1] && m_mask[1];
        e_ierr = |(m_evt & m_mask & 32'h0000_FF00);
        @(posedge clk);
        @(negedge clk);
        check("R2 rsp_valid", 32'(rsp_valid), 32'(e_rv));
        if (e_rv) check({e_tag, " rsp_rdata"}, rsp_rdata, e_rd);
        check("R4 tx_restart", 32'(tx_restart), 32'(e_txr));
        check("R5 rx_restart", 32'(rx_restart), 32'(e_rxr));
        check("R8 irq_tx", 32'(irq_tx), 32'(e_itx));
        check("R8 irq_rx", 32'(irq_rx), 32'(e_irx));
        check("R9 irq_err", 32'(irq_err), 32'(e_ierr));
        check("R3 cmd_word", cmd_word, m_cmd);
        check("R3 dma_ctl", dma_ctl, m_ctl);
    endtask

    task automatic rd(input logic [11:0] a);
        step(1'b1, 1'b0, a, 32'h0, 32'h0, '0, '0);
    endtask

    task automatic wrt(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d, 32'h0, '0, '0);
    endtask

    task automatic idle(input logic [31:0] es, input logic [NR-1:0] th, input logic [NR-1:0] rh);
        step(1'b0, 1'b0, 12'h0, 32'h0, es, th, rh);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    localparam logic [11:0] PICK [16] = '{
        12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
        12'h100, 12'h11C, 12'h140, 12'h15C, 12'h184, 12'h1A0, 12'h1C4, 12'hFFC
    };

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state at the ports
        check("R10 rsp_valid", 32'(rsp_valid), 32'h0);
        check("R10 irq", {29'h0, irq_tx, irq_rx, irq_err}, 32'h0);
        check("R10 restarts", {16'h0, tx_restart, rx_restart}, 32'h0);
        // R10: every register after reset
        for (int i = 0; i < 8; i++) rd(12'(i * 4));
        for (int i = 0; i < 8; i++) rd(12'h100 + 12'(i * 16 * 4) / 4 * 4 + 12'(i * 4));
        rd(12'h300); rd(12'hFFC);

        // R3: read-write, write-only, read-only, undefined
        wrt(12'h004, 32'hDEAD_BEEF); rd(12'h004);
        wrt(12'h008, 32'h1234_5678); rd(12'h008);
        wrt(12'h014, 32'hCAFE_F00D); rd(12'h014);
        wrt(12'h018, 32'hFFFF_FFFF); rd(12'h018);
        wrt(12'h01C, 32'hFFFF_FFFF); rd(12'h01C);
        wrt(12'h120, 32'hFFFF_FFFF); rd(12'h120);
        // R1: low address bits ignored
        wrt(12'h007, 32'h0000_00A5); rd(12'h006); rd(12'h009);

        // R4: tx halt flags and restarts
        idle(32'h0, 8'hA5, 8'h0); rd(12'h00C);
        wrt(12'h00C, 32'h8100_0000); rd(12'h00C);
        wrt(12'h00C, 32'hFF00_0000); rd(12'h00C);
        wrt(12'h00C, 32'hFF00_0000); // restarts even with flags clear

        // R5: rx restart only where the stored flag was clear
        idle(32'h0, 8'h0, 8'h0F); rd(12'h010);
        wrt(12'h010, 32'h00FF_0000); rd(12'h010);
        wrt(12'h010, 32'h0081_0000);
        step(1'b1, 1'b1, 12'h010, 32'h0080_0000, 32'h0, 8'h0, 8'h01); rd(12'h010);

        // R6: base loads aligned value into pointer
        wrt(12'h100, 32'h1000_0007); rd(12'h100); rd(12'h140);
        wrt(12'h11C, 32'h2000_00FF); rd(12'h11C); rd(12'h15C);
        wrt(12'h140, 32'h3333_3337); rd(12'h140); rd(12'h100);
        wrt(12'h194, 32'h4444_4445); rd(12'h194); rd(12'h1D4);
        wrt(12'h1C0, 32'h5555_5553); rd(12'h1C0); rd(12'h180);

        // R7, R8, R9: events and interrupts
        wrt(12'h004, 32'h0000_0000);
        idle(32'h0000_0003, '0, '0);      // events set, masked off
        wrt(12'h004, 32'h0000_0001);      // tx interrupt appears
        wrt(12'h004, 32'h0000_0003);
        wrt(12'h000, 32'h0000_0001); rd(12'h000);
        step(1'b1, 1'b1, 12'h000, 32'h0000_0002, 32'h0000_0002, '0, '0); rd(12'h000);
        wrt(12'h004, 32'hFFFF_FFFF);
        idle(32'h00FF_00FC, '0, '0); rd(12'h000); // no error-class bits
        idle(32'h0000_1000, '0, '0); rd(12'h000);
        wrt(12'h000, 32'h0000_1000); rd(12'h000);
        wrt(12'h000, 32'hFFFF_FFFF); rd(12'h000);

        // mixed traffic
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] es;
            logic [NR-1:0] th, rh;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            es = (lfsr[7:5] == 3'b000) ? (32'h1 << lfsr[20:16]) : 32'h0;
            th = (lfsr[9:8] == 2'b00) ? NR'(1 << lfsr[12:10]) : '0;
            rh = (lfsr[14:13] == 2'b00) ? NR'(1 << lfsr[27:25]) : '0;
            step(lfsr[0], lfsr[1], PICK[lfsr[31:28]] | {10'h0, lfsr[3:2]},
                 {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_0F0F, es, th, rh);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule